// File: doc/BRIEF.md
# Privilege Mode and Address Window Guard

This block keeps the processor's privilege level in a single mode bit and screens every memory access against a window set by a base register and a limit register. In the privileged monitor mode every address passes, and only monitor mode may load the window and the time-slice timer. In user mode an access passes only when it falls inside the window. An access outside the window, an attempt to load a register, an external interrupt or trap, or expiry of the time-slice timer all return the processor to monitor mode.

The access check is combinational, so the grant or fault for an access is valid in the cycle the access is presented. The mode bit, the window registers and the timer are registers, so their changes take effect at the next clock edge. The block does not translate addresses. It only judges accesses and raises signals.

Top module: `priv_guard`

## Requirements
- R1: While reset is held and directly after it, the block is in monitor mode (user_mode = 0), base = 0, limit = 0, the timer is stopped, and acc_fault, priv_fault and tmr_irq are low.
- R2: The mode bit reads 0 in monitor mode and 1 in user mode. ret_user in monitor mode sets user_mode to 1 at the next edge, unless a trap or fault occurs in the same cycle. In user mode, ret_user has no effect.
- R3: evt_trap high in any cycle makes user_mode 0 from the next edge on.
- R4: In user mode, a valid access with base <= addr < base + limit raises acc_grant and leaves acc_fault low in the same cycle. When limit = 0, no address is inside the window.
- R5: In user mode, a valid access outside the window raises acc_fault with acc_grant low in the same cycle, and user_mode is 0 from the next edge.
- R6: In monitor mode, every valid access is granted and acc_fault stays low, whatever base and limit hold.
- R7: The sum base + limit is formed one bit wider than the address, so it never wraps. With base = 0xFF00 and limit = 0x0200, address 0xFFFF passes and address 0x0010 faults.
- R8: A monitor-mode write takes effect at the next edge. wr_sel 0 loads base, 1 loads limit, and 2 loads the timer. wr_sel 3 has no effect.
- R9: A write attempt in user mode raises priv_fault in the same cycle and changes none of the registers. user_mode is 0 from the next edge.
- R10: A nonzero timer decrements on each cycle with tick high. The tick that takes it from 1 to 0 produces a one-cycle tmr_irq pulse starting at the next edge, and user_mode is 0 in that same cycle. The timer then stays at 0 until it is loaded again, and loading 0 leaves it stopped. A timer load in the same cycle as a tick wins over the decrement.
- R11: A trap or fault in the same cycle as ret_user leaves the block in monitor mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | AW | Physical address of the access |
| evt_trap | input | 1 | External interrupt, fault or trap event |
| ret_user | input | 1 | Request to drop to user mode |
| wr_en | input | 1 | Register load request |
| wr_sel | input | 2 | Register select: 0 base, 1 limit, 2 timer, 3 none |
| wr_data | input | AW | Load value; the timer takes the low TW bits |
| tick | input | 1 | Timer decrement enable |
| user_mode | output | 1 | Mode bit: 0 monitor, 1 user |
| acc_grant | output | 1 | Access allowed this cycle |
| acc_fault | output | 1 | Access is outside the window in user mode |
| priv_fault | output | 1 | Register load attempted in user mode |
| tmr_irq | output | 1 | One-cycle pulse when the timer expires |

## Verification
acc_grant, acc_fault and priv_fault depend on the inputs of the same cycle. user_mode changes one edge after its cause, and tmr_irq rises one edge after the tick that empties the timer. The bench applies inputs just after a rising edge and samples every output at the following falling edge. At that point it compares them against a behavioural model whose state advances only after the comparison, so combinational results are checked in their own cycle and registered results in the cycle after their cause. State that has no port of its own is observed through later accesses and interrupt timing.

// File: rtl/priv_guard.sv
module priv_guard #(
  parameter int AW = 16,
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  input  logic [AW-1:0] acc_addr,
  input  logic          evt_trap,
  input  logic          ret_user,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [AW-1:0] wr_data,
  input  logic          tick,
  output logic          user_mode,
  output logic          acc_grant,
  output logic          acc_fault,
  output logic          priv_fault,
  output logic          tmr_irq
);
  localparam logic [1:0] SEL_BASE = 2'd0;
  localparam logic [1:0] SEL_LIM  = 2'd1;
  localparam logic [1:0] SEL_TMR  = 2'd2;
  localparam logic [TW-1:0] ONE   = TW'(1);

  logic          mode_q;
  logic [AW-1:0] base_q, lim_q;
  logic [TW-1:0] cnt_q;
  logic          irq_q;

  wire [AW:0] lo_w   = {1'b0, base_q};
  wire [AW:0] hi_w   = lo_w + {1'b0, lim_q};
  wire [AW:0] addr_w = {1'b0, acc_addr};
  wire        in_win = (addr_w >= lo_w) && (addr_w < hi_w);

  assign acc_fault  = acc_valid & mode_q & ~in_win;
  assign acc_grant  = acc_valid & ~acc_fault;
  assign priv_fault = wr_en & mode_q;
  assign user_mode  = mode_q;
  assign tmr_irq    = irq_q;

  wire wr_ok    = wr_en & ~mode_q;
  wire tmr_load = wr_ok && (wr_sel == SEL_TMR);
  wire expire   = tick && (cnt_q == ONE) && !tmr_load;
  wire to_mon   = evt_trap | acc_fault | priv_fault | expire;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      base_q <= '0;
      lim_q  <= '0;
      cnt_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (to_mon)
        mode_q <= 1'b0;
      else if (ret_user && !mode_q)
        mode_q <= 1'b1;

      if (wr_ok && wr_sel == SEL_BASE) base_q <= wr_data;
      if (wr_ok && wr_sel == SEL_LIM)  lim_q  <= wr_data;

      if (tmr_load)
        cnt_q <= wr_data[TW-1:0];
      else if (tick && cnt_q != '0)
        cnt_q <= cnt_q - ONE;

      irq_q <= expire;
    end
  end
endmodule

// File: rtl/priv_guard_chk.sv
module priv_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic evt_trap,
  input logic ret_user,
  input logic user_mode,
  input logic acc_grant,
  input logic acc_fault,
  input logic priv_fault,
  input logic tmr_irq
);
  p_trap_mon_r3: assert property (@(posedge clk) disable iff (!rst_n)
    evt_trap |=> !user_mode);

  p_fault_mon_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fault |=> !user_mode);

  p_priv_mon_r9: assert property (@(posedge clk) disable iff (!rst_n)
    priv_fault |=> !user_mode);

  p_irq_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_irq |=> !tmr_irq);

  p_irq_mon_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_irq |-> !user_mode);

  p_ret_user_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_user && !user_mode && !evt_trap && !acc_fault && !priv_fault)
      |=> (user_mode || tmr_irq));

  p_mon_open_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !user_mode |-> !acc_fault);

  p_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_fault && acc_grant));

  p_trap_ret_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_trap && ret_user) |=> !user_mode);
endmodule

bind priv_guard priv_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .evt_trap(evt_trap), .ret_user(ret_user),
  .user_mode(user_mode), .acc_grant(acc_grant), .acc_fault(acc_fault),
  .priv_fault(priv_fault), .tmr_irq(tmr_irq)
);

// File: tb/sim_priv_guard.sv
`timescale 1ns/1ps
module sim_priv_guard;
  localparam int AW = 16;
  localparam int TW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_valid = 1'b0, evt_trap = 1'b0, ret_user = 1'b0, wr_en = 1'b0, tick = 1'b0;
  logic [AW-1:0] acc_addr = '0, wr_data = '0;
  logic [1:0] wr_sel = '0;
  logic user_mode, acc_grant, acc_fault, priv_fault, tmr_irq;

  always #2.5 clk = ~clk;

  priv_guard #(.AW(AW), .TW(TW)) u0 (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .evt_trap(evt_trap), .ret_user(ret_user), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .tick(tick), .user_mode(user_mode), .acc_grant(acc_grant),
    .acc_fault(acc_fault), .priv_fault(priv_fault), .tmr_irq(tmr_irq)
  );

  int checks = 0, failures = 0;
  int m_mode, m_base, m_lim, m_cnt, m_irq;
  bit finished = 0;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_mode = 0; m_base = 0; m_lim = 0; m_cnt = 0; m_irq = 0;
  endtask

  // one cycle: inputs already driven; check at negedge, then advance model and clock
  task automatic cyc(string req, bit v, int a, bit trp, bit ret, bit we, int sel, int d, bit tk);
    longint lo, hi;
    int e_fault, e_grant, e_pf, wr_ok, load, e_exp, tomon;
    acc_valid = v; acc_addr = AW'(a); evt_trap = trp; ret_user = ret;
    wr_en = we; wr_sel = 2'(sel); wr_data = AW'(d); tick = tk;
    @(negedge clk);
    lo = m_base; hi = longint'(m_base) + longint'(m_lim);
    e_fault = (rst_n && v && m_mode == 1 && !(a >= lo && a < hi)) ? 1 : 0;
    e_grant = (v && e_fault == 0) ? 1 : 0;
    e_pf    = (rst_n && we && m_mode == 1) ? 1 : 0;
    chk(req, "user_mode", int'(user_mode), m_mode);
    chk(req, "acc_fault", int'(acc_fault), e_fault);
    chk(req, "acc_grant", int'(acc_grant), e_grant);
    chk(req, "priv_fault", int'(priv_fault), e_pf);
    chk(req, "tmr_irq", int'(tmr_irq), m_irq);
    if (!rst_n) begin
      model_reset();
    end else begin
      wr_ok = (we && m_mode == 0) ? 1 : 0;
      load  = (wr_ok != 0 && sel == 2) ? 1 : 0;
      e_exp = (tk && m_cnt == 1 && load == 0) ? 1 : 0;
      tomon = (trp || e_fault != 0 || e_pf != 0 || e_exp != 0) ? 1 : 0;
      if (tomon != 0) m_mode = 0;
      else if (ret && m_mode == 0) m_mode = 1;
      if (wr_ok != 0 && sel == 0) m_base = d;
      if (wr_ok != 0 && sel == 1) m_lim = d;
      if (load != 0) m_cnt = d % (1 << TW);
      else if (tk && m_cnt != 0) m_cnt = m_cnt - 1;
      m_irq = e_exp;
    end
    @(posedge clk);
    #1;
  endtask

  task automatic idle(string req);
    cyc(req, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic acc(string req, int a);
    cyc(req, 1, a, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic wr(string req, int sel, int d);
    cyc(req, 0, 0, 0, 0, 1, sel, d, 0);
  endtask
  task automatic to_user(string req);
    cyc(req, 0, 0, 0, 1, 0, 0, 0, 0);
  endtask
  task automatic tk(string req);
    cyc(req, 0, 0, 0, 0, 0, 0, 0, 1);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    model_reset();
    #1;
    repeat (3) idle("R1");
    rst_n = 1'b1;
    idle("R1");
    to_user("R1"); // limit 0 after reset: any user access faults
    acc("R4", 16'h0000);
    idle("R1");
    // R6: monitor mode passes all addresses
    acc("R6", 16'hFFFF);
    acc("R6", 16'h0000);
    // R8: register loads
    wr("R8", 0, 16'h1000);
    wr("R8", 1, 16'h0100);
    wr("R8", 3, 16'h0000);
    // R2: enter user mode, repeat has no effect
    to_user("R2");
    to_user("R2");
    acc("R4", 16'h1000);
    acc("R4", 16'h10FF);
    acc("R5", 16'h1100);
    idle("R5");
    to_user("R2");
    acc("R5", 16'h0FFF);
    to_user("R2");
    // R9: user write refused
    wr("R9", 0, 16'h0000);
    to_user("R9");
    acc("R9", 16'h1000);
    acc("R9", 16'h0000);
    // R3: trap
    to_user("R3");
    cyc("R3", 0, 0, 1, 0, 0, 0, 0, 0);
    idle("R3");
    // R7: no wrap of base + limit
    wr("R7", 0, 16'hFF00);
    wr("R7", 1, 16'h0200);
    to_user("R7");
    acc("R7", 16'hFFFF);
    acc("R7", 16'hFF00);
    acc("R7", 16'h0010);
    // R11: trap with ret in same cycle, and fault with ret
    to_user("R11");
    cyc("R11", 0, 0, 1, 1, 0, 0, 0, 0);
    idle("R11");
    cyc("R11", 1, 16'h0010, 1, 1, 0, 0, 0, 0);
    idle("R11");
    // R10: timer
    wr("R10", 2, 3);
    to_user("R10");
    tk("R10");
    idle("R10");
    tk("R10");
    tk("R10");
    idle("R10");
    tk("R10");
    tk("R10");
    idle("R10");
    wr("R10", 2, 0);
    to_user("R10");
    tk("R10");
    tk("R10");
    idle("R10");
    // R10: load beats tick; user-mode load ignored
    wr("R10", 2, 1);
    cyc("R10", 0, 0, 0, 0, 1, 2, 2, 1);
    tk("R10");
    idle("R10");
    tk("R10");
    idle("R10");
    wr("R10", 2, 2);
    to_user("R10");
    cyc("R10", 0, 0, 0, 0, 1, 2, 9, 1);
    to_user("R10");
    tk("R10");
    idle("R10");
    // R4: limit 0 empties the window
    wr("R4", 1, 0);
    to_user("R4");
    acc("R4", 16'hFF00);
    idle("R4");
    // R1: reset in user mode
    wr("R1", 1, 16'h0100);
    to_user("R1");
    rst_n = 1'b0;
    idle("R1");
    rst_n = 1'b1;
    idle("R1");
    to_user("R1");
    acc("R1", 16'hFF00);
    idle("R1");
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule